// File: doc/BRIEF.md
# Serial SAR ADC Readout Controller

This block is the host side of a 16-bit successive-approximation converter that reports its progress through a busy flag and returns its result over one serial data line. A free-running period timer paces the conversions. On each period tick, if the controller is idle, it pulls the convert strobe and the chip select low together for a fixed number of cycles. It then waits for the converter's busy flag to fall and rise again, passing the flag through a two-stage synchronizer. Only after that does it generate a shaped data clock and shift in the 16 result bits, most significant bit first.

The finished word leaves on a valid/ready output. `out_valid_o` rises with the word and stays high until `out_ready_i` is seen high at a clock edge. While the word waits, no new conversion starts and any period ticks that occur are dropped. When the host holds `out_ready_i` high, the handshake becomes a single-cycle pulse. `out_data_o` keeps the last delivered word until the next one arrives.

A coding input can turn straight binary into two's complement, or the other way round, by inverting the top bit. A converter whose busy flag never completes its low-then-high cycle within a bounded time sets a sticky error, and the controller goes back to waiting for the next tick.

Top module: `sar_readout_ctrl`

## Requirements
- R1: `conv_n_o` and `cs_n_o` go low together for exactly STROBE_CYC cycles (default 3). A strobe starts only on a period tick while the controller is idle, so the gap between two strobe starts is always a whole multiple of PERIOD_CYC (default 250).
- R2: No data clock pulse appears between the start of a strobe and the converter's busy flag returning high after it has been low.
- R3: Each readout produces exactly 16 data clock pulses. Each pulse is high for SCLK_HI cycles and low for SCLK_LO cycles (default 2 and 2). `cs_n_o` is low throughout the readout.
- R4: The bit presented after the k-th rising data clock edge (k = 1..16) becomes bit 16-k of the result, so the first bit is the MSB. Each bit is sampled in the last cycle of the low phase that follows its launching edge.
- R5: `out_valid_o` stays high with `out_data_o` unchanged until `out_ready_i` is high at a clock edge. No strobe is issued while `out_valid_o` is high.
- R6: `out_data_o` changes only when a new result is presented and otherwise holds the last result.
- R7: With `fmt_flip_i` = 1 while a result is captured, bit 15 of that result is inverted. Bits 14..0 are never altered. With `fmt_flip_i` = 0 the word is passed through unchanged.
- R8: If, BUSY_TO cycles (default 220) after the strobe ends, busy has not completed its low-then-high sequence, `timeout_err_o` rises exactly BUSY_TO cycles after `conv_n_o` returns high. It then stays high until reset, that conversion produces no result, and later conversions proceed normally.
- R9: During reset `conv_n_o` = 1, `cs_n_o` = 1, `sclk_o` = 0, `out_valid_o` = 0, `timeout_err_o` = 0 and `out_data_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy_i | input | 1 | Converter busy flag; low while a conversion runs (asynchronous) |
| sdata_i | input | 1 | Serial result bit from the converter |
| fmt_flip_i | input | 1 | 1 = invert the MSB of the result (binary / two's complement swap) |
| out_ready_i | input | 1 | Host accepts the presented word |
| conv_n_o | output | 1 | Active-low convert strobe |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Data clock driven to the converter |
| out_valid_o | output | 1 | Result word present |
| out_data_o | output | 16 | Result word |
| timeout_err_o | output | 1 | Sticky busy-timeout error |

## Verification
The behaviour is anchored to two events: the cycle the strobe falls and the cycle `conv_n_o` rises again. The strobe width must be STROBE_CYC, and the distance between strobe starts must be a multiple of PERIOD_CYC. The error flag must appear exactly BUSY_TO cycles after `conv_n_o` rises, measured on the same falling-edge sampling grid. Readout results have no fixed latency, because the busy length varies. The bench's converter model therefore queues each expected word when its strobe is seen, and compares every cycle in which `out_valid_o` is high against the head of that queue. The high and low phases of the data clock are counted cycle by cycle, and each pulse length is compared with SCLK_HI and SCLK_LO as it ends.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STROBE,
    ST_WAIT_LO,
    ST_WAIT_HI,
    ST_SHIFT,
    ST_DONE
  } sar_state_e;
endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
  parameter int PERIOD_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(PERIOD_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sar_busy_sync.sv
module sar_busy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) ff <= '1;
        else        ff <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) ff <= '1;
        else        ff <= {ff[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = ff[STAGES-1];
endmodule

// File: rtl/sar_clk_shaper.sv
module sar_clk_shaper #(
  parameter int SCLK_HI = 2,
  parameter int SCLK_LO = 2,
  parameter int NBITS   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic sample,
  output logic last
);
  localparam int PER = SCLK_HI + SCLK_LO;
  localparam int PW  = (PER > 1) ? $clog2(PER) : 1;
  localparam int BW  = (NBITS > 1) ? $clog2(NBITS) : 1;

  logic [PW-1:0] phase;
  logic [BW-1:0] bitc;
  logic          wrap;

  assign wrap   = (phase == PW'(PER - 1));
  assign sclk   = run && (phase < PW'(SCLK_HI));
  assign sample = run && wrap;
  assign last   = sample && (bitc == BW'(NBITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      phase <= '0;
      bitc  <= '0;
    end else if (wrap) begin
      phase <= '0;
      bitc  <= bitc + 1'b1;
    end else begin
      phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/sar_shift_in.sv
module sar_shift_in #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n)  word <= '0;
    else if (en) word <= {word[W-2:0], din};
  end
endmodule

// File: rtl/sar_readout_ctrl.sv
module sar_readout_ctrl
  import sar_pkg::*;
#(
  parameter int W           = 16,
  parameter int STROBE_CYC  = 3,
  parameter int PERIOD_CYC  = 250,
  parameter int BUSY_TO     = 220,
  parameter int SCLK_HI     = 2,
  parameter int SCLK_LO     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         busy_i,
  input  logic         sdata_i,
  input  logic         fmt_flip_i,
  input  logic         out_ready_i,
  output logic         conv_n_o,
  output logic         cs_n_o,
  output logic         sclk_o,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o,
  output logic         timeout_err_o
);
  localparam int SCW = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
  localparam int TOW = $clog2(BUSY_TO + 1);

  sar_state_e     st;
  logic [SCW-1:0] scnt;
  logic [TOW-1:0] tcnt;
  logic           tick, busy_s, shift_run, smp, smp_last, to_hit;
  logic [W-1:0]   sreg, captured, coded;

  sar_tick_gen #(.PERIOD_CYC(PERIOD_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  sar_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(busy_i), .q(busy_s));

  sar_clk_shaper #(.SCLK_HI(SCLK_HI), .SCLK_LO(SCLK_LO), .NBITS(W)) u_shaper (
    .clk(clk), .rst_n(rst_n), .run(shift_run),
    .sclk(sclk_o), .sample(smp), .last(smp_last));

  sar_shift_in #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(smp), .din(sdata_i), .word(sreg));

  assign shift_run = (st == ST_SHIFT);
  assign captured  = {sreg[W-2:0], sdata_i};
  assign coded     = captured ^ {fmt_flip_i, {(W-1){1'b0}}};
  assign to_hit    = (tcnt >= TOW'(BUSY_TO - 1));

  assign conv_n_o    = (st != ST_STROBE);
  assign cs_n_o      = !((st == ST_STROBE) || (st == ST_SHIFT));
  assign out_valid_o = (st == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= ST_IDLE;
      scnt          <= '0;
      tcnt          <= '0;
      timeout_err_o <= 1'b0;
      out_data_o    <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (tick) begin
            st   <= ST_STROBE;
            scnt <= '0;
          end
        end
        ST_STROBE: begin
          if (scnt == SCW'(STROBE_CYC - 1)) begin
            st   <= ST_WAIT_LO;
            tcnt <= '0;
          end else begin
            scnt <= scnt + 1'b1;
          end
        end
        ST_WAIT_LO: begin
          tcnt <= tcnt + 1'b1;
          if (!busy_s) st <= ST_WAIT_HI;
          else if (to_hit) begin
            timeout_err_o <= 1'b1;
            st            <= ST_IDLE;
          end
        end
        ST_WAIT_HI: begin
          tcnt <= tcnt + 1'b1;
          if (busy_s) st <= ST_SHIFT;
          else if (to_hit) begin
            timeout_err_o <= 1'b1;
            st            <= ST_IDLE;
          end
        end
        ST_SHIFT: begin
          if (smp_last) begin
            st         <= ST_DONE;
            out_data_o <= coded;
          end
        end
        ST_DONE: begin
          if (out_ready_i) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_readout_chk.sv
module sar_readout_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         conv_n_o,
  input logic         cs_n_o,
  input logic         sclk_o,
  input logic         out_ready_i,
  input logic         out_valid_o,
  input logic [W-1:0] out_data_o,
  input logic         timeout_err_o
);
  AST_STROBE_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_n_o |-> !cs_n_o); // R1

  AST_NO_SCLK_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> conv_n_o); // R2

  AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> !cs_n_o); // R3

  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o))); // R5

  AST_NO_STROBE_WHILE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> conv_n_o); // R5

  AST_DATA_ONLY_ON_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_data_o) |-> $rose(out_valid_o)); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err_o |=> timeout_err_o); // R8
endmodule

bind sar_readout_ctrl sar_readout_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_n_o(conv_n_o), .cs_n_o(cs_n_o),
  .sclk_o(sclk_o), .out_ready_i(out_ready_i), .out_valid_o(out_valid_o),
  .out_data_o(out_data_o), .timeout_err_o(timeout_err_o));

// File: tb/sar_readout_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_readout_ctrl_tb_top;
  localparam int W = 16, STROBE_CYC = 3, PERIOD_CYC = 250, BUSY_TO = 220;
  localparam int SCLK_HI = 2, SCLK_LO = 2, WD_CYC = 100000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic busy = 1'b1, sdata = 1'b0, fmt_flip = 1'b0, out_ready = 1'b1;
  logic conv_n, cs_n, sclk, out_valid, timeout_err;
  logic [W-1:0] out_data;

  always #10 clk = ~clk;

  sar_readout_ctrl #(.W(W), .STROBE_CYC(STROBE_CYC), .PERIOD_CYC(PERIOD_CYC),
    .BUSY_TO(BUSY_TO), .SCLK_HI(SCLK_HI), .SCLK_LO(SCLK_LO), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .sdata_i(sdata), .fmt_flip_i(fmt_flip),
    .out_ready_i(out_ready), .conv_n_o(conv_n), .cs_n_o(cs_n), .sclk_o(sclk),
    .out_valid_o(out_valid), .out_data_o(out_data), .timeout_err_o(timeout_err));

  int checks = 0, fails = 0, ncyc = 0, res_cnt = 0, conv_id = 0;
  logic finished = 1'b0;

  // converter model stimulus: {stuck, busy_len, word}
  int      st_len[$];
  bit      st_stuck[$];
  logic [W-1:0] st_word[$];
  logic [W-1:0] exp_q[$];
  logic [W-1:0] cur_word = '0, last_res = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, ncyc);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  // serial data launch: bit k shown ~30 ns after the k-th rising data clock
  int last_id = -1, pidx = 0;
  always @(posedge sclk) begin
    if (conv_id != last_id) begin last_id = conv_id; pidx = 0; end
    #30;
    sdata = (pidx < W) ? cur_word[W-1-pidx] : 1'b0;
    pidx++;
  end

  // behavioural converter + per-cycle comparison
  logic p_conv = 1'b1, p_sclk = 1'b0, p_valid = 1'b0, p_err = 1'b0;
  int bdelay = 0, blen = 0, slen = 0, hi_run = 0, lo_run = 0, pulses = 0;
  int prev_start = -1, t_rise = 0;
  bit stuck = 0, awaiting = 0;

  always @(posedge clk) ncyc++;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(conv_n && cs_n && !sclk && !out_valid && !timeout_err && out_data == '0,
          "R9", {conv_n, cs_n, sclk, out_valid, timeout_err}, 5'b11000);
    end else begin
      // strobe start
      if (!conv_n && p_conv) begin
        chk(!out_valid, "R5 strobe while valid", out_valid, 0);
        if (prev_start >= 0)
          chk((ncyc - prev_start) % PERIOD_CYC == 0, "R1 spacing", ncyc - prev_start, PERIOD_CYC);
        prev_start = ncyc;
        conv_id++;
        pulses = 0; lo_run = 0; slen = 0; awaiting = 1;
        if (st_word.size() > 0) begin
          cur_word = st_word.pop_front(); blen = st_len.pop_front(); stuck = st_stuck.pop_front();
        end else begin
          cur_word = 16'h1234; blen = 40; stuck = 0;
        end
        if (!stuck) exp_q.push_back(cur_word ^ {fmt_flip, 15'd0});
        bdelay = 2;
      end
      if (!conv_n) begin
        slen++;
        chk(!cs_n, "R1 cs with strobe", cs_n, 0);
      end
      if (conv_n && !p_conv) begin
        chk(slen == STROBE_CYC, "R1 width", slen, STROBE_CYC);
        t_rise = ncyc;
      end
      // busy model
      if (!stuck) begin
        if (bdelay > 0) begin
          bdelay--;
          if (bdelay == 0) busy = 1'b0;
        end else if (!busy) begin
          blen--;
          if (blen <= 0) begin busy = 1'b1; awaiting = 0; end
        end
      end
      // data clock shape
      if (sclk && !p_sclk) begin
        chk(!awaiting, "R2 clock before busy done", awaiting, 0);
        if (pulses > 0) chk(lo_run == SCLK_LO, "R3 low phase", lo_run, SCLK_LO);
        pulses++; hi_run = 0;
      end
      if (sclk) hi_run++; else lo_run++;
      if (sclk) lo_run = 0;
      if (!sclk && p_sclk) chk(hi_run == SCLK_HI, "R3 high phase", hi_run, SCLK_HI);
      if (sclk) chk(!cs_n, "R3 cs during readout", cs_n, 0);
      // output side
      if (out_valid) begin
        if (!p_valid) chk(pulses == W, "R3 pulse count", pulses, W);
        if (exp_q.size() == 0) chk(0, "R8 unexpected result", out_data, 0);
        else chk(out_data == exp_q[0], "R4/R7 result", out_data, exp_q[0]);
        if (out_ready) begin
          if (exp_q.size() > 0) void'(exp_q.pop_front());
          last_res = out_data; res_cnt++;
        end
      end else if (res_cnt > 0) begin
        chk(out_data == last_res, "R6 hold", out_data, last_res);
      end
      if (timeout_err && !p_err)
        chk(ncyc - t_rise == BUSY_TO, "R8 timeout latency", ncyc - t_rise, BUSY_TO);
    end
    p_conv = conv_n; p_sclk = sclk; p_valid = out_valid; p_err = timeout_err;
  end

  task automatic push(input logic [W-1:0] w, input int len, input bit stk);
    st_word.push_back(w); st_len.push_back(len); st_stuck.push_back(stk);
  endtask

  task automatic wait_results(input int n);
    while (res_cnt < n) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R4: MSB-first assembly over several patterns, varying busy length (R2)
    push(16'h0000, 5, 0);  push(16'hFFFF, 150, 0); push(16'hA5C3, 40, 0);
    push(16'h8000, 80, 0); push(16'h7FFF, 12, 0);  push(16'h0001, 100, 0);
    wait_results(6);
    // R7: MSB inversion
    fmt_flip = 1'b1;
    push(16'h8000, 30, 0); push(16'h7FFF, 30, 0); push(16'h5A5A, 60, 0);
    wait_results(9);
    fmt_flip = 1'b0;
    // R5: back-pressure
    out_ready = 1'b0;
    push(16'hC0DE, 20, 0); push(16'h0F0F, 20, 0);
    while (!out_valid) @(negedge clk);
    repeat (700) @(negedge clk);
    chk(out_valid && out_data == 16'hC0DE, "R5 held under back-pressure", out_data, 16'hC0DE);
    out_ready = 1'b1;
    wait_results(11);
    // R8: converter never asserts busy
    chk(!timeout_err, "R8 error clear before timeout", timeout_err, 0);
    push(16'hDEAD, 0, 1); push(16'h3C3C, 25, 0);
    while (!timeout_err) @(negedge clk);
    wait_results(12);
    chk(timeout_err, "R8 sticky", timeout_err, 1);
    chk(exp_q.size() == 0, "R8 no stray results", exp_q.size(), 0);
    finished = 1'b1;
    finish_run();
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<%0d cycles", WD_CYC, WD_CYC);
      finish_run();
    end
  end
endmodule